// File: doc/BRIEF.md
# Handshake Word Bridge Between Asynchronous Clocks

This block carries one multi-bit word at a time from a source clock to an unrelated destination clock. The sender offers a word on a valid/ready pair. When the block accepts it, the word goes into a hold register and a request level rises. The request reaches the destination through a chain of flip-flops whose length is a parameter. The destination takes the word from the hold register, raises an acknowledge, and reports the word with a one-cycle valid pulse. The acknowledge returns through a second flip-flop chain of the same length.

The exchange is four-phase and returns to zero. After the source sees the synchronized acknowledge, it drops the request. It then waits for the synchronized acknowledge to fall before it accepts another word. The destination drives acknowledge high for exactly as long as its synchronized copy of the request is high. Each domain has its own active-low asynchronous reset.

Back-pressure on the source side works as follows. `src_ready` is high only when the bridge is idle. A word moves only on a source clock edge where `src_valid` and `src_ready` are both high. `src_valid` raised while ready is low does nothing, and the sender may drop it or hold it. The destination side has no back-pressure: each word appears once, as a single-cycle `dst_valid` pulse, and `dst_data` keeps that word until the next capture.

Top module: `xdom_word_bridge`

## Requirements
- R1: When either reset is asserted, its own side returns to the idle state: `src_ready`=1, `src_busy`=0, `dst_valid`=0, `dst_data`=0.
- R2: A word is accepted on a `s_clk` edge where `src_valid`=1 and `src_ready`=1. On that edge `src_ready` falls and `src_busy` rises. `src_busy` is always the inverse of `src_ready`.
- R3: Each accepted word appears unchanged on `dst_data` in the same `d_clk` cycle as its `dst_valid` pulse.
- R4: Every accepted word produces exactly one `dst_valid` pulse, and that pulse lasts exactly one `d_clk` cycle.
- R5: A `src_valid` strobe while `src_ready`=0 is ignored. It delivers no extra word and does not change the word in flight.
- R6: The request passes through `SYNC_STAGES` (at least 2) `d_clk` flops before it is acted on. As a result, `dst_valid` cannot rise earlier than the (`SYNC_STAGES`+1)-th rising `d_clk` edge after the accepting `s_clk` edge.
- R7: The source stays busy until the destination has captured the word and the synchronized acknowledge has fallen again. `src_ready` therefore never returns before the `dst_valid` pulse of the word in flight.
- R8: The acknowledge is high in the cycle after the synchronized request is high, and low in the cycle after it is low. A new acknowledge therefore needs the request to fall and rise again.
- R9: The word in the hold register does not change while the source is busy.
- R10: Between captures, `dst_data` keeps the last delivered word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_clk | input | 1 | Source clock |
| s_rst_n | input | 1 | Source reset, active low, asynchronous |
| src_valid | input | 1 | Sender offers a word |
| src_ready | output | 1 | Bridge idle; a word is taken this edge if valid |
| src_data | input | WIDTH | Word offered by the sender |
| src_busy | output | 1 | Transfer in progress (inverse of ready) |
| d_clk | input | 1 | Destination clock |
| d_rst_n | input | 1 | Destination reset, active low, asynchronous |
| dst_valid | output | 1 | One-cycle pulse: new word on dst_data |
| dst_data | output | WIDTH | Last captured word |

## Verification
The in-design properties assume that both resets are released on the falling edge of their own clock. They also assume that the sender changes `src_valid` and `src_data` only away from the rising `s_clk` edge, so that each domain sees settled inputs. The bench drives every input on the falling edge of its clock. The two clock periods are chosen so that the two sets of rising edges never coincide. The bench never offers a word while ready is low, except for the deliberate ignored strobes that R5 requires.

// File: rtl/xdom_bridge_pkg.sv
package xdom_bridge_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_REQ  = 2'd1,
    SRC_DROP = 2'd2
  } src_state_t;

  typedef enum logic {
    DST_WAIT = 1'b0,
    DST_HOLD = 1'b1
  } dst_state_t;
endpackage

// File: rtl/xdom_level_sync.sv
module xdom_level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic level_out
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[LAST-1:0], level_in};
  end

  assign level_out = chain[LAST];

  // R6: the output is the input seen one stage later down the chain
  a_r6_chain_shift: assert property (@(posedge clk) disable iff (!rst_n)
    chain[0] |=> chain[1]);
endmodule

// File: rtl/xdom_src_ctrl.sv
module xdom_src_ctrl
  import xdom_bridge_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  input  logic             ack_sync,
  output logic             in_ready,
  output logic             busy,
  output logic             req,
  output logic [WIDTH-1:0] hold_data
);
  src_state_t state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SRC_IDLE;
      req       <= 1'b0;
      hold_data <= '0;
    end else begin
      case (state)
        SRC_IDLE: if (in_valid) begin
          hold_data <= in_data;
          req       <= 1'b1;
          state     <= SRC_REQ;
        end
        SRC_REQ: if (ack_sync) begin
          req   <= 1'b0;
          state <= SRC_DROP;
        end
        SRC_DROP: if (!ack_sync) state <= SRC_IDLE;
        default: state <= SRC_IDLE;
      endcase
    end
  end

  assign in_ready = (state == SRC_IDLE);
  assign busy     = !in_ready;

  a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  a_r9_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(hold_data));

  a_r7_no_rerequest_before_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && ack_sync) |=> !req);

  a_r7_idle_needs_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> !ack_sync);
endmodule

// File: rtl/xdom_dst_ctrl.sv
module xdom_dst_ctrl
  import xdom_bridge_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_sync,
  input  logic [WIDTH-1:0] src_word,
  output logic             ack,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data
);
  dst_state_t state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= DST_WAIT;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        DST_WAIT: if (req_sync) begin
          out_data  <= src_word;
          out_valid <= 1'b1;
          state     <= DST_HOLD;
        end
        DST_HOLD: if (!req_sync) state <= DST_WAIT;
        default: state <= DST_WAIT;
      endcase
    end
  end

  assign ack = (state == DST_HOLD);

  a_r8_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_sync |=> ack);

  a_r8_ack_drops_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    !req_sync |=> !ack);

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r3_capture_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> out_valid);

  a_r10_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !req_sync |=> $stable(out_data));
endmodule

// File: rtl/xdom_word_bridge.sv
module xdom_word_bridge #(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             s_clk,
  input  logic             s_rst_n,
  input  logic             src_valid,
  output logic             src_ready,
  input  logic [WIDTH-1:0] src_data,
  output logic             src_busy,
  input  logic             d_clk,
  input  logic             d_rst_n,
  output logic             dst_valid,
  output logic [WIDTH-1:0] dst_data
);
  logic             req, req_sync;
  logic             ack, ack_sync;
  logic [WIDTH-1:0] hold_data;

  xdom_src_ctrl #(.WIDTH(WIDTH)) u_src (
    .clk       (s_clk),
    .rst_n     (s_rst_n),
    .in_valid  (src_valid),
    .in_data   (src_data),
    .ack_sync  (ack_sync),
    .in_ready  (src_ready),
    .busy      (src_busy),
    .req       (req),
    .hold_data (hold_data)
  );

  xdom_level_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk       (d_clk),
    .rst_n     (d_rst_n),
    .level_in  (req),
    .level_out (req_sync)
  );

  xdom_dst_ctrl #(.WIDTH(WIDTH)) u_dst (
    .clk       (d_clk),
    .rst_n     (d_rst_n),
    .req_sync  (req_sync),
    .src_word  (hold_data),
    .ack       (ack),
    .out_valid (dst_valid),
    .out_data  (dst_data)
  );

  xdom_level_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk       (s_clk),
    .rst_n     (s_rst_n),
    .level_in  (ack),
    .level_out (ack_sync)
  );

  a_r2_busy_is_not_ready: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    src_busy != src_ready);
endmodule

// File: tb/test_xdom_word_bridge.sv
`timescale 1ns/1ps
module test_xdom_word_bridge;
  localparam int WIDTH       = 16;
  localparam int SYNC_STAGES = 2;
  localparam int SRC_PERIOD  = 10;
  localparam int DST_PERIOD  = 14;
  localparam int NVEC        = 8;
  localparam int TMO         = 200;

  localparam logic [WIDTH-1:0] VEC [NVEC] = '{
    16'hA5C3, 16'h0000, 16'hFFFF, 16'h1234,
    16'h8001, 16'h5A5A, 16'h00FF, 16'hBEEF
  };

  logic s_clk = 1'b0, d_clk = 1'b0;
  logic s_rst_n = 1'b0, d_rst_n = 1'b0;
  logic src_valid = 1'b0;
  logic [WIDTH-1:0] src_data = '0;
  logic src_ready, src_busy, dst_valid;
  logic [WIDTH-1:0] dst_data;

  int n_chk = 0, n_bad = 0;
  int d_edges = 0, pulses = 0, doubles = 0, valid_edge = 0, acc_edge = 0;
  logic [WIDTH-1:0] last_data = '0;
  logic prev_v = 1'b0;

  always #(SRC_PERIOD/2) s_clk = ~s_clk;
  initial begin
    #1;
    forever #(DST_PERIOD/2) d_clk = ~d_clk;
  end

  xdom_word_bridge #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) i_xdom_word_bridge (
    .s_clk(s_clk), .s_rst_n(s_rst_n), .src_valid(src_valid), .src_ready(src_ready),
    .src_data(src_data), .src_busy(src_busy), .d_clk(d_clk), .d_rst_n(d_rst_n),
    .dst_valid(dst_valid), .dst_data(dst_data)
  );

  always @(posedge d_clk) d_edges <= d_edges + 1;

  always @(negedge d_clk) begin
    if (dst_valid) begin
      pulses++;
      last_data = dst_data;
      valid_edge = d_edges;
      if (prev_v) doubles++;
    end
    prev_v = dst_valid;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // offer a word once ready, then wait for its delivery; inject ignored strobes when asked
  task automatic send(input logic [WIDTH-1:0] w, input bit poke);
    int base, t;
    bit early;
    t = 0;
    @(negedge s_clk);
    while (!src_ready && t < TMO) begin @(negedge s_clk); t++; end
    check("R7 ready before send", {31'd0, src_ready}, 32'd1);
    base = pulses;
    src_valid = 1'b1;
    src_data  = w;
    @(posedge s_clk);
    acc_edge = d_edges;
    @(negedge s_clk);
    src_valid = 1'b0;
    check("R2 busy after accept", {30'd0, src_busy, src_ready}, 32'd2);
    early = 1'b0;
    t = 0;
    while (pulses == base && t < TMO) begin
      if (poke) begin src_valid = 1'b1; src_data = ~w; end
      @(negedge s_clk);
      if (src_ready && pulses == base) early = 1'b1;
      t++;
    end
    src_valid = 1'b0;
    check("R7 no ready before delivery", {31'd0, early}, 32'd0);
    check("R4 one pulse per word", pulses - base, 32'd1);
    check("R3 R9 delivered word", {16'd0, last_data}, {16'd0, w});
    check("R6 latency floor", {31'd0, (valid_edge - acc_edge) >= SYNC_STAGES + 1}, 32'd1);
  endtask

  initial begin
    #(SRC_PERIOD * 190000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge s_clk);
    // R1: reset state
    check("R1 ready in reset", {31'd0, src_ready}, 32'd1);
    check("R1 busy in reset", {31'd0, src_busy}, 32'd0);
    check("R1 valid in reset", {31'd0, dst_valid}, 32'd0);
    check("R1 data in reset", {16'd0, dst_data}, 32'd0);
    @(negedge d_clk); d_rst_n = 1'b1;
    @(negedge s_clk); s_rst_n = 1'b1;
    repeat (2) @(negedge s_clk);

    for (int i = 0; i < NVEC; i++) send(VEC[i], i[0]);

    // R5: pokes on odd words added no words
    check("R5 total pulses", pulses, NVEC);
    check("R4 no double-wide pulse", doubles, 32'd0);
    repeat (30) @(negedge s_clk);
    check("R10 data held", {16'd0, dst_data}, {16'd0, VEC[NVEC-1]});
    check("R8 no spurious pulse", pulses, NVEC);

    // reset in the middle of a transfer
    @(negedge s_clk);
    src_valid = 1'b1; src_data = 16'h7777;
    @(negedge s_clk);
    src_valid = 1'b0;
    s_rst_n = 1'b0;
    @(negedge d_clk); d_rst_n = 1'b0;
    @(negedge s_clk);
    check("R1 ready after mid reset", {31'd0, src_ready}, 32'd1);
    check("R1 valid after mid reset", {31'd0, dst_valid}, 32'd0);
    check("R1 data after mid reset", {16'd0, dst_data}, 32'd0);
    @(negedge d_clk); d_rst_n = 1'b1;
    @(negedge s_clk); s_rst_n = 1'b1;
    repeat (6) @(negedge d_clk);
    send(16'hC0DE, 1'b0);
    check("R4 no double-wide pulse end", doubles, 32'd0);
    finish_run();
  end
endmodule